// File: doc/BRIEF.md
# FIFO-Fed Serial Word Transmitter

This block turns 16-bit words into a single serial bit stream. Software-side logic pushes words into a 16-entry queue through a simple write port. Each accepted tick of an external bit clock, given as a one-cycle strobe in the system clock domain, moves the line on by one bit. Words go out back to back, 8 or 16 bits long, in either bit order. The line rests high whenever no word is being shifted.

An optional flag mode uses the lowest bit of each queued word as a marker. The marker is normally 0. A write to the separate control word register arms a one-shot slot. The next queued word then leaves with its marker set to 1, and the control word follows it with no gap. Three sticky status flags report on the queue. The first is a low-level flag, set when a word leaves and the count still queued is at or below a programmed threshold. The second is an underrun flag, set when a word is due and none is queued. The third is an overflow flag, set when a write reaches a full queue. An interrupt output follows the underrun flag through an enable bit.

Top module: `sio_fifo_tx`

## Requirements
- R1: Each cycle with `bitTick` and `txEn` both high moves the line by exactly one bit. A tick while `txEn` is low changes neither `txData` nor `fifoLevel`.
- R2: With `cfgMsbFirst` = 1, a word's bits leave from the highest sent bit down to bit 0. With 0, they leave from bit 0 upward.
- R3: With `cfgLen16` = 0, only bits 7..0 of a word are sent (8 ticks per word). With 1, all 16 bits are sent (16 ticks per word).
- R4: Words written with `wrSel` = 0 leave in write order. `fifoLevel` reports how many are queued, up to 16.
- R5: `txData` is 1 whenever no word is in the shifter: after reset and after an underrun.
- R6: With `cfgFlagMode` = 1 and no armed control word, a queued word leaves with bit 0 forced to 0. With `cfgFlagMode` = 0, words leave unmodified, and an armed control word is neither sent nor disarmed.
- R7: With `cfgFlagMode` = 1 and a control word armed (a write with `wrSel` = 1), the next queued word leaves with bit 0 forced to 1. The control word follows at once, with the same length and order. `ctlPending` drops when it starts, and the following queued word carries bit 0 = 0 again.
- R8: When a queued word enters the shifter and the words still queued number at most `cfgWatermark`, `flagEmpty` is set.
- R9: An accepted tick at a word boundary, with no queued word and no control slot due, sets `flagUnderrun` and leaves the line idle.
- R10: A write with `wrSel` = 0 while 16 words are queued is discarded and sets `flagOverflow`.
- R11: Each flag stays set until its clear input is pulsed. `irq` equals `flagUnderrun` AND `cfgErrIrqEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | 0: push to queue, 1: load control word |
| wrData | input | 16 | Write data |
| cfgMsbFirst | input | 1 | Bit order select |
| cfgLen16 | input | 1 | Word length: 0 = 8 bits, 1 = 16 bits |
| cfgFlagMode | input | 1 | Marker bit and control slot mode |
| cfgWatermark | input | 4 | Low-level threshold |
| cfgErrIrqEn | input | 1 | Underrun interrupt enable |
| txEn | input | 1 | Transmit enable |
| bitTick | input | 1 | One-cycle strobe per serial clock rising edge |
| clrEmpty | input | 1 | Clears flagEmpty |
| clrUnderrun | input | 1 | Clears flagUnderrun |
| clrOverflow | input | 1 | Clears flagOverflow |
| txData | output | 1 | Serial data line |
| fifoLevel | output | 5 | Queued word count |
| ctlPending | output | 1 | Control word armed |
| flagEmpty | output | 1 | Low-level flag |
| flagUnderrun | output | 1 | Underrun flag |
| flagOverflow | output | 1 | Overflow flag |
| irq | output | 1 | Error interrupt |

## Verification
A stale bit counter or a wrong load position shows on `txData` at the first word boundary. The next word then starts a tick early or late, so every bit after it is displaced. A corrupt queue pointer shows as a wrong word within one word time, or as a `fifoLevel` that disagrees with the writes and pops counted. Control slot faults need the flag mode: a pending marker lost or kept too long shows in the very next word's bit 0, or as an extra or missing control word. The bench therefore compares every bit of every word across all length and order settings.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  localparam int WORD_W = 16;
  localparam int QUEUE_DEPTH = 16;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic popPrim;   // load a queued word into the shifter
    logic loadCtl;   // load the control word into the shifter
    logic shiftBit;  // advance the shifter by one bit
    logic flagLsb;   // marker value for a popped word in flag mode
  } txStrobes_t;
endpackage

// File: rtl/sio_tx_fifo.sv
module sio_tx_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head = mem[rdPtr];
endmodule

// File: rtl/sio_tx_ctrl.sv
module sio_tx_ctrl
  import sio_tx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int WM_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic             bitTick,
  input  logic             cfgLen16,
  input  logic             cfgFlagMode,
  input  logic [WM_W-1:0]  cfgWatermark,
  input  logic             wrFifo,
  input  logic             wrCtl,
  input  logic [LVL_W-1:0] level,
  input  logic             clrEmpty,
  input  logic             clrUnderrun,
  input  logic             clrOverflow,
  output txStrobes_t       strb,
  output logic             pushOk,
  output logic             busy,
  output logic             ctlPending,
  output logic             flagEmpty,
  output logic             flagUnderrun,
  output logic             flagOverflow
);
  logic [CNT_W-1:0] bitsLeft;
  logic             ctlNext;
  logic             tick, fifoEmpty, fifoFull, underrunHit, loading;
  logic             setEmpty, setOverflow;
  logic [CNT_W-1:0] wordLen;

  assign tick      = bitTick & txEn;
  assign fifoEmpty = (level == '0);
  assign fifoFull  = (level == LVL_W'(DEPTH));
  assign wordLen   = cfgLen16 ? CNT_W'(DATA_W) : CNT_W'(DATA_W / 2);
  assign pushOk    = wrFifo & ~fifoFull;

  always_comb begin
    strb        = '0;
    underrunHit = 1'b0;
    if (tick) begin
      if (busy && bitsLeft > CNT_W'(1)) begin
        strb.shiftBit = 1'b1;
      end else if (ctlNext) begin
        strb.loadCtl = 1'b1;
      end else if (!fifoEmpty) begin
        strb.popPrim = 1'b1;
        strb.flagLsb = ctlPending;
      end else begin
        underrunHit = 1'b1;
      end
    end
  end

  assign loading     = strb.popPrim | strb.loadCtl;
  assign setEmpty    = strb.popPrim && ((level - LVL_W'(1)) <= LVL_W'(cfgWatermark));
  assign setOverflow = wrFifo & fifoFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      bitsLeft     <= '0;
      ctlNext      <= 1'b0;
      ctlPending   <= 1'b0;
      flagEmpty    <= 1'b0;
      flagUnderrun <= 1'b0;
      flagOverflow <= 1'b0;
    end else begin
      if (loading) begin
        busy     <= 1'b1;
        bitsLeft <= wordLen;
      end else if (strb.shiftBit) begin
        bitsLeft <= bitsLeft - 1'b1;
      end else if (underrunHit) begin
        busy     <= 1'b0;
        bitsLeft <= '0;
      end

      if (strb.popPrim)      ctlNext <= cfgFlagMode & ctlPending;
      else if (strb.loadCtl) ctlNext <= 1'b0;

      if (wrCtl)             ctlPending <= 1'b1;
      else if (strb.loadCtl) ctlPending <= 1'b0;

      flagEmpty    <= (flagEmpty & ~clrEmpty) | setEmpty;
      flagUnderrun <= (flagUnderrun & ~clrUnderrun) | underrunHit;
      flagOverflow <= (flagOverflow & ~clrOverflow) | setOverflow;
    end
  end
endmodule

// File: rtl/sio_tx_datapath.sv
module sio_tx_datapath
  import sio_tx_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strb,
  input  logic              cfgMsbFirst,
  input  logic              cfgLen16,
  input  logic              cfgFlagMode,
  input  logic              wrCtl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] head,
  output logic              curBit
);
  logic [DATA_W-1:0] ctlReg, shReg, rawWord, alignedWord;

  always_comb begin
    rawWord = strb.loadCtl ? ctlReg : head;
    if (strb.popPrim && cfgFlagMode) rawWord[0] = strb.flagLsb;
    if (cfgLen16)         alignedWord = rawWord;
    else if (cfgMsbFirst) alignedWord = {rawWord[HALF_W-1:0], {HALF_W{1'b0}}};
    else                  alignedWord = {{HALF_W{1'b0}}, rawWord[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0;
      shReg  <= '0;
    end else begin
      if (wrCtl) ctlReg <= wrData;
      if (strb.popPrim || strb.loadCtl) shReg <= alignedWord;
      else if (strb.shiftBit)           shReg <= cfgMsbFirst ? (shReg << 1) : (shReg >> 1);
    end
  end

  assign curBit = cfgMsbFirst ? shReg[DATA_W-1] : shReg[0];
endmodule

// File: rtl/sio_fifo_tx.sv
module sio_fifo_tx
  import sio_tx_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int DEPTH = QUEUE_DEPTH,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int WM_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgMsbFirst,
  input  logic              cfgLen16,
  input  logic              cfgFlagMode,
  input  logic [WM_W-1:0]   cfgWatermark,
  input  logic              cfgErrIrqEn,
  input  logic              txEn,
  input  logic              bitTick,
  input  logic              clrEmpty,
  input  logic              clrUnderrun,
  input  logic              clrOverflow,
  output logic              txData,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              ctlPending,
  output logic              flagEmpty,
  output logic              flagUnderrun,
  output logic              flagOverflow,
  output logic              irq
);
  txStrobes_t        strb;
  logic              wrFifo, wrCtl, pushOk, busy, curBit;
  logic [DATA_W-1:0] head;

  assign wrFifo = wrEn & ~wrSel;
  assign wrCtl  = wrEn & wrSel;

  sio_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .push(pushOk), .pop(strb.popPrim),
    .pushData(wrData), .head(head), .level(fifoLevel)
  );

  sio_tx_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .bitTick(bitTick),
    .cfgLen16(cfgLen16), .cfgFlagMode(cfgFlagMode), .cfgWatermark(cfgWatermark),
    .wrFifo(wrFifo), .wrCtl(wrCtl), .level(fifoLevel),
    .clrEmpty(clrEmpty), .clrUnderrun(clrUnderrun), .clrOverflow(clrOverflow),
    .strb(strb), .pushOk(pushOk), .busy(busy), .ctlPending(ctlPending),
    .flagEmpty(flagEmpty), .flagUnderrun(flagUnderrun), .flagOverflow(flagOverflow)
  );

  sio_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgMsbFirst(cfgMsbFirst),
    .cfgLen16(cfgLen16), .cfgFlagMode(cfgFlagMode), .wrCtl(wrCtl),
    .wrData(wrData), .head(head), .curBit(curBit)
  );

  assign txData = busy ? curBit : 1'b1;
  assign irq    = flagUnderrun & cfgErrIrqEn;
endmodule

// File: rtl/sio_fifo_tx_chk.sv
module sio_fifo_tx_chk #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int WM_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrSel,
  input logic             txEn,
  input logic             bitTick,
  input logic [WM_W-1:0]  cfgWatermark,
  input logic             clrUnderrun,
  input logic             busy,
  input logic             txData,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             flagEmpty,
  input logic             flagUnderrun,
  input logic             flagOverflow
);
  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH));

  a_r1_no_tick_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(bitTick && txEn) && !wrEn) |=> $stable(fifoLevel));

  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txData);

  a_r9_underrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagUnderrun) |-> ($past(fifoLevel) == '0 && $past(bitTick && txEn)));

  a_r10_overflow_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOverflow) |-> ($past(fifoLevel) == LVL_W'(DEPTH) && $past(wrEn && !wrSel)));

  a_r8_empty_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagEmpty) |-> ($past(fifoLevel) <= LVL_W'($past(cfgWatermark)) + LVL_W'(1)));

  a_r11_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagUnderrun && !clrUnderrun) |=> flagUnderrun);
endmodule

bind sio_fifo_tx sio_fifo_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .txEn(txEn),
  .bitTick(bitTick), .cfgWatermark(cfgWatermark), .clrUnderrun(clrUnderrun),
  .busy(busy), .txData(txData), .fifoLevel(fifoLevel), .flagEmpty(flagEmpty),
  .flagUnderrun(flagUnderrun), .flagOverflow(flagOverflow)
);

// File: tb/sio_fifo_tx_tb.sv
module sio_fifo_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic        cfgMsbFirst = 1'b0, cfgLen16 = 1'b0, cfgFlagMode = 1'b0;
  logic [3:0]  cfgWatermark = '0;
  logic        cfgErrIrqEn = 1'b0, txEn = 1'b0, bitTick = 1'b0;
  logic        clrEmpty = 1'b0, clrUnderrun = 1'b0, clrOverflow = 1'b0;
  logic        txData;
  logic [4:0]  fifoLevel;
  logic        ctlPending, flagEmpty, flagUnderrun, flagOverflow, irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio_fifo_tx u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cfgMsbFirst(cfgMsbFirst), .cfgLen16(cfgLen16), .cfgFlagMode(cfgFlagMode),
    .cfgWatermark(cfgWatermark), .cfgErrIrqEn(cfgErrIrqEn), .txEn(txEn),
    .bitTick(bitTick), .clrEmpty(clrEmpty), .clrUnderrun(clrUnderrun),
    .clrOverflow(clrOverflow), .txData(txData), .fifoLevel(fifoLevel),
    .ctlPending(ctlPending), .flagEmpty(flagEmpty), .flagUnderrun(flagUnderrun),
    .flagOverflow(flagOverflow), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tickBit();
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
  endtask

  task automatic writeWord(input logic sel, input logic [15:0] d);
    @(negedge clk) begin wrEn = 1'b1; wrSel = sel; wrData = d; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic pulseClr(input int which);
    @(negedge clk) begin
      clrEmpty = (which == 0);
      clrUnderrun = (which == 1);
      clrOverflow = (which == 2);
    end
    @(negedge clk) begin clrEmpty = 0; clrUnderrun = 0; clrOverflow = 0; end
  endtask

  // sends one word and compares every bit; bit order and length from current cfg
  task automatic expectWord(input string tag, input logic [15:0] w);
    int len = cfgLen16 ? 16 : 8;
    for (int i = 0; i < len; i++) begin
      tickBit();
      chk(tag, int'(txData), int'(cfgMsbFirst ? w[len - 1 - i] : w[i]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5 R4 R11 reset state
    chk("R5 idle after reset", int'(txData), 1);
    chk("R4 level after reset", int'(fifoLevel), 0);
    chk("R11 flags after reset", int'({flagEmpty, flagUnderrun, flagOverflow, irq}), 0);

    // R2 R3 R4 sweep over length and order
    txEn = 1'b1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      cfgLen16 = cfg[1];
      cfgMsbFirst = cfg[0];
      for (int k = 0; k < 4; k++)
        writeWord(1'b0, 16'hA53C ^ 16'(k * 16'h01B7) ^ 16'(cfg * 16'h0F0F));
      chk("R4 level after writes", int'(fifoLevel), 4);
      for (int k = 0; k < 4; k++)
        expectWord(cfg[1] ? "R3 R2 sweep len16" : "R3 R2 sweep len8",
                   16'hA53C ^ 16'(k * 16'h01B7) ^ 16'(cfg * 16'h0F0F));
    end
    chk("R9 no underrun while fed", int'(flagUnderrun), 0);

    // R1 ticks ignored while disabled
    cfgLen16 = 1'b0; cfgMsbFirst = 1'b1;
    writeWord(1'b0, 16'h0096);
    txEn = 1'b0;
    begin
      logic held = txData;
      for (int i = 0; i < 3; i++) tickBit();
      chk("R1 disabled level", int'(fifoLevel), 1);
      chk("R1 disabled line", int'(txData), int'(held));
    end
    txEn = 1'b1;
    expectWord("R1 word after enable", 16'h0096);

    // R6 flag mode, nothing armed: bit 0 forced low
    cfgFlagMode = 1'b1; cfgLen16 = 1'b1;
    writeWord(1'b0, 16'h1235);
    expectWord("R6 marker low", 16'h1234);

    // R6 mode off: armed control word is ignored
    cfgFlagMode = 1'b0;
    writeWord(1'b1, 16'hBEEF);
    writeWord(1'b0, 16'h00F1);
    writeWord(1'b0, 16'h0F0F);
    expectWord("R6 unmodified", 16'h00F1);
    expectWord("R6 no control slot", 16'h0F0F);
    chk("R6 still armed", int'(ctlPending), 1);

    // R7 flagged word then control word, 16-bit MSB first
    cfgFlagMode = 1'b1;
    writeWord(1'b1, 16'hC3A5);
    writeWord(1'b0, 16'h4444);
    writeWord(1'b0, 16'h5555);
    expectWord("R7 marker high", 16'h4445);
    expectWord("R7 control follows", 16'hC3A5);
    chk("R7 pending consumed", int'(ctlPending), 0);
    expectWord("R7 next marker low", 16'h5554);

    // R7 8-bit LSB first
    cfgLen16 = 1'b0; cfgMsbFirst = 1'b0;
    writeWord(1'b1, 16'h12A7);
    writeWord(1'b0, 16'h0038);
    expectWord("R7 len8 marker high", 16'h0039);
    expectWord("R7 len8 control", 16'h00A7);
    chk("R7 len8 consumed", int'(ctlPending), 0);

    // R9 underrun at word boundary, R5 idle, R11 irq and stickiness
    cfgFlagMode = 1'b0; cfgErrIrqEn = 1'b1;
    chk("R9 before underrun", int'(flagUnderrun), 0);
    tickBit();
    chk("R9 underrun set", int'(flagUnderrun), 1);
    chk("R5 idle after underrun", int'(txData), 1);
    chk("R11 irq enabled", int'(irq), 1);
    cfgErrIrqEn = 1'b0;
    #1 chk("R11 irq masked", int'(irq), 0);
    repeat (3) @(negedge clk);
    chk("R11 underrun sticky", int'(flagUnderrun), 1);
    pulseClr(1);
    chk("R11 underrun cleared", int'(flagUnderrun), 0);

    // R8 watermark, 8-bit words
    cfgWatermark = 4'd3;
    pulseClr(0);
    for (int k = 0; k < 6; k++) writeWord(1'b0, 16'(8'h11 * (k + 1)));
    for (int k = 0; k < 6; k++) begin
      w = 16'(8'h11 * (k + 1));
      tickBit();
      chk("R8 first bit", int'(txData), int'(w[0]));
      chk("R4 level after pop", int'(fifoLevel), 5 - k);
      chk("R8 empty flag", int'(flagEmpty), (5 - k) <= 3 ? 1 : 0);
      pulseClr(0);
      for (int i = 1; i < 8; i++) begin
        tickBit();
        chk("R8 word bits", int'(txData), int'(w[i]));
      end
    end

    // R10 overflow, 17th write discarded
    txEn = 1'b0;
    for (int k = 0; k < 17; k++) writeWord(1'b0, 16'(16'h0101 * k + 16'h0003));
    chk("R10 level full", int'(fifoLevel), 16);
    chk("R10 overflow set", int'(flagOverflow), 1);
    txEn = 1'b1;
    for (int k = 0; k < 16; k++) expectWord("R10 kept words", 16'(16'h0101 * k + 16'h0003));
    pulseClr(1);
    tickBit();
    chk("R10 extra word discarded", int'(flagUnderrun), 1);
    chk("R11 overflow sticky", int'(flagOverflow), 1);
    pulseClr(2);
    chk("R11 overflow cleared", int'(flagOverflow), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule